// File: doc/BRIEF.md
# Windowed Translation Request Coalescer

This block sits in front of a downstream translation lookaside buffer. It accepts one address-translation request per cycle, each carrying a virtual address, a read/write access mode, a prefetch flag, a requester ID and a count of the original requests it stands for. Requests that arrive in the same time window, target the same virtual page and use the same access mode are merged into one group. Only the group's first member is presented downstream as a probe.

Up to `LANES` groups are offered in parallel each cycle. A single downstream ready strobe accepts every lane that is valid. A group that has been accepted moves into a small outstanding table keyed by virtual page. While its page stays in that table, any other group for the same page is held back and younger groups may pass it. A downstream response naming the page frees the entry.

Top module: `xlat_coalescer`

## Requirements
- R1: An accepted request joins an open group when all of these hold: its window key, its page number (`req_vaddr_i[VA_W-1:PAGE_BITS]`) and its mode (`req_write_i`, 0 = read, 1 = write) equal the group's, the group has fewer than `MAX_MEMB` members, and the group is not issued in that cycle. The probe carries the vaddr, source and mode of the group's first member, and `probe_members_o` carries the member count.
- R2: A read and a write to the same page never share a group.
- R3: The window key of a request is the number of clock cycles since reset release divided by `WIN_LEN`, taken in the cycle the request is accepted. Requests with different keys form separate groups.
- R4: While `coalesce_off_i` is high, every accepted request opens a group of its own.
- R5: A group's count starts at the `req_cnt_i` of its first member and adds the `req_cnt_i` of each member that joins later. A member with `req_prefetch_i` high adds 0, whether it opens the group or joins it.
- R6: At most `LANES` groups are presented per cycle, in allocation order with lane 0 the oldest, and lanes fill from 0 upward. When `probe_ready_i` is high at a clock edge, every valid lane is issued at that edge.
- R7: A group whose page is in the outstanding table is not presented, and a younger eligible group of the same window is presented in its place. Two lanes never show the same page in one cycle.
- R8: Only groups of the oldest window still held are presented. Groups of a later window wait until every group of that window has issued.
- R9: While `probe_ready_i` is low, the groups stay buffered, and the group on lane 0 stays there until a response arrives or it is issued.
- R10: Each issued group occupies one of `OUT_DEPTH` outstanding entries. A response (`rsp_valid_i`, `rsp_vpn_i`) frees the matching entry at the end of its cycle, so a group for that page can be presented from the next cycle on. The number of lanes presented never exceeds the number of free entries.
- R11: After reset no lane is valid and `req_ready_o` is high. `req_ready_o` is low exactly while all `GROUPS` group slots are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coalesce_off_i | input | 1 | Disables merging |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | A group slot is free |
| req_vaddr_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | Access mode, 1 = write |
| req_prefetch_i | input | 1 | Prefetch request |
| req_src_i | input | SRC_W | Requester ID |
| req_cnt_i | input | CNT_W | Requests represented |
| probe_valid_o | output | LANES | Lane valid |
| probe_ready_i | input | 1 | Downstream accepts all valid lanes |
| probe_vaddr_o | output | LANES x VA_W | First member's address |
| probe_write_o | output | LANES | Group mode |
| probe_src_o | output | LANES x SRC_W | First member's requester |
| probe_cnt_o | output | LANES x CNT_W | Group count |
| probe_members_o | output | LANES x MW | Members in group |
| rsp_valid_i | input | 1 | Translation returned |
| rsp_vpn_i | input | VPN_W | Page of returned translation |

## Verification
The bench uses the default parameters: eight group slots of up to eight members, two lanes, a four-entry outstanding table, a four-cycle window and 4 KiB pages. With these values, eight requests are enough to fill the group storage and drop `req_ready_o`. Four issues exhaust the outstanding table, a window boundary falls every four cycles, and three groups in one window exceed the lane count. This lets each stall, boundary and skip case be reached with short directed sequences whose expected probes are worked out by hand.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {MODE_RD = 1'b0, MODE_WR = 1'b1} acc_mode_e;
  localparam int unsigned DEF_GROUPS    = 8;
  localparam int unsigned DEF_MAX_MEMB  = 8;
  localparam int unsigned DEF_LANES     = 2;
  localparam int unsigned DEF_OUT_DEPTH = 4;
  localparam int unsigned DEF_WIN_LEN   = 4;
endpackage

// File: rtl/tc_window_timer.sv
module tc_window_timer #(
  parameter int unsigned WIN_LEN = 4,
  parameter int unsigned WIN_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIN_W-1:0] win_o
);
  localparam int unsigned PH_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WIN_LEN - 1);

  logic [PH_W-1:0]  phase_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      win_q   <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      win_q   <= win_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/tc_inflight_table.sv
module tc_inflight_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned LANES = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            alloc_vld_i,
  input  logic [LANES-1:0][VPN_W-1:0] alloc_vpn_i,
  input  logic                        rel_vld_i,
  input  logic [VPN_W-1:0]            rel_vpn_i,
  output logic [DEPTH-1:0]            busy_vld_o,
  output logic [DEPTH-1:0][VPN_W-1:0] busy_vpn_o,
  output logic [CW-1:0]               free_cnt_o
);
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][VPN_W-1:0] vpn_q;
  logic [DEPTH-1:0]            take;
  logic [DEPTH-1:0][VPN_W-1:0] take_vpn;

  // lane k lands in the k-th free slot
  always_comb begin
    int unsigned nfree;
    nfree    = 0;
    take     = '0;
    take_vpn = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (!vld_q[s]) begin
        for (int k = 0; k < LANES; k++) begin
          if (alloc_vld_i[k] && (k == nfree)) begin
            take[s]     = 1'b1;
            take_vpn[s] = alloc_vpn_i[k];
          end
        end
        nfree = nfree + 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      vpn_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (take[s]) begin
          vld_q[s] <= 1'b1;
          vpn_q[s] <= take_vpn[s];
        end else if (vld_q[s] && rel_vld_i && (vpn_q[s] == rel_vpn_i)) begin
          vld_q[s] <= 1'b0;
        end
      end
    end
  end

  assign busy_vld_o = vld_q;
  assign busy_vpn_o = vpn_q;
  assign free_cnt_o = CW'($countones(~vld_q));
endmodule

// File: rtl/tc_issue_pick.sv
module tc_issue_pick #(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned WIN_W  = 16,
  localparam int unsigned GI_W  = $clog2(GROUPS),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [GROUPS-1:0]             grp_vld_i,
  input  logic [GROUPS-1:0][VPN_W-1:0]  grp_vpn_i,
  input  logic [GROUPS-1:0][WIN_W-1:0]  grp_win_i,
  input  logic [GROUPS-1:0][GROUPS-1:0] grp_older_i,
  input  logic [DEPTH-1:0]              busy_vld_i,
  input  logic [DEPTH-1:0][VPN_W-1:0]   busy_vpn_i,
  input  logic [CW-1:0]                 free_cnt_i,
  output logic [LANES-1:0]              lane_vld_o,
  output logic [LANES-1:0][GI_W-1:0]    lane_idx_o
);
  localparam int unsigned RW = GI_W + 1;

  logic [WIN_W-1:0]           head_win;
  logic [GROUPS-1:0]          cand;
  logic [GROUPS-1:0]          pick;
  logic [GROUPS-1:0][RW-1:0]  rank;

  always_comb begin
    head_win = '0;
    cand     = '0;
    pick     = '0;
    rank     = '0;
    // oldest live group defines the window being drained
    for (int i = 0; i < GROUPS; i++)
      if (grp_vld_i[i] && !(|(grp_older_i[i] & grp_vld_i))) head_win = grp_win_i[i];
    for (int i = 0; i < GROUPS; i++) begin
      logic blk;
      blk = 1'b0;
      for (int d = 0; d < DEPTH; d++)
        if (busy_vld_i[d] && (busy_vpn_i[d] == grp_vpn_i[i])) blk = 1'b1;
      cand[i] = grp_vld_i[i] && (grp_win_i[i] == head_win) && !blk;
    end
    // an older same-page candidate shadows younger ones
    for (int i = 0; i < GROUPS; i++) begin
      pick[i] = cand[i];
      for (int j = 0; j < GROUPS; j++)
        if (cand[j] && grp_older_i[i][j] && (grp_vpn_i[j] == grp_vpn_i[i])) pick[i] = 1'b0;
    end
    for (int i = 0; i < GROUPS; i++) rank[i] = RW'($countones(grp_older_i[i] & pick));
  end

  always_comb begin
    lane_vld_o = '0;
    lane_idx_o = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int i = 0; i < GROUPS; i++) begin
        if (pick[i] && (rank[i] == RW'(k)) && (k < 32'(free_cnt_i))) begin
          lane_vld_o[k] = 1'b1;
          lane_idx_o[k] = GI_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/xlat_coalescer.sv
module xlat_coalescer
  import tc_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned GROUPS    = DEF_GROUPS,
  parameter int unsigned MAX_MEMB  = DEF_MAX_MEMB,
  parameter int unsigned LANES     = DEF_LANES,
  parameter int unsigned OUT_DEPTH = DEF_OUT_DEPTH,
  parameter int unsigned WIN_LEN   = DEF_WIN_LEN,
  parameter int unsigned WIN_W     = 16,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned MW       = $clog2(MAX_MEMB + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        coalesce_off_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [VA_W-1:0]             req_vaddr_i,
  input  logic                        req_write_i,
  input  logic                        req_prefetch_i,
  input  logic [SRC_W-1:0]            req_src_i,
  input  logic [CNT_W-1:0]            req_cnt_i,
  output logic [LANES-1:0]            probe_valid_o,
  input  logic                        probe_ready_i,
  output logic [LANES-1:0][VA_W-1:0]  probe_vaddr_o,
  output logic [LANES-1:0]            probe_write_o,
  output logic [LANES-1:0][SRC_W-1:0] probe_src_o,
  output logic [LANES-1:0][CNT_W-1:0] probe_cnt_o,
  output logic [LANES-1:0][MW-1:0]    probe_members_o,
  input  logic                        rsp_valid_i,
  input  logic [VPN_W-1:0]            rsp_vpn_i
);
  localparam int unsigned GI_W = $clog2(GROUPS);
  localparam int unsigned CW   = $clog2(OUT_DEPTH + 1);

  typedef struct packed {
    logic [VA_W-1:0]  vaddr;
    logic [SRC_W-1:0] src;
    acc_mode_e        mode;
    logic [WIN_W-1:0] win;
    logic [CNT_W-1:0] cnt;
    logic [MW-1:0]    memb;
  } grp_t;

  grp_t                         grp_q [GROUPS];
  logic [GROUPS-1:0]            vld_q;
  logic [GROUPS-1:0][GROUPS-1:0] older_q;   // [i][j]: j allocated before i
  logic [GROUPS-1:0][VPN_W-1:0] grp_vpn;
  logic [GROUPS-1:0][WIN_W-1:0] grp_win;
  logic [WIN_W-1:0]             cur_win;
  logic [OUT_DEPTH-1:0]         busy_vld;
  logic [OUT_DEPTH-1:0][VPN_W-1:0] busy_vpn;
  logic [CW-1:0]                free_cnt;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][GI_W-1:0]   lane_idx;
  logic [LANES-1:0][VPN_W-1:0]  lane_vpn;
  logic [GROUPS-1:0]            fire;
  logic                         hit, free_any, accept;
  logic [GI_W-1:0]              hit_idx, free_idx;
  logic [VPN_W-1:0]             req_vpn;
  acc_mode_e                    req_mode;
  logic [CNT_W-1:0]             add;

  for (genvar i = 0; i < GROUPS; i++) begin : g_view
    assign grp_vpn[i] = grp_q[i].vaddr[VA_W-1:PAGE_BITS];
    assign grp_win[i] = grp_q[i].win;
  end

  tc_window_timer #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_o(cur_win)
  );

  tc_inflight_table #(.DEPTH(OUT_DEPTH), .VPN_W(VPN_W), .LANES(LANES)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_vld_i(lane_vld & {LANES{probe_ready_i}}), .alloc_vpn_i(lane_vpn),
    .rel_vld_i(rsp_valid_i), .rel_vpn_i(rsp_vpn_i),
    .busy_vld_o(busy_vld), .busy_vpn_o(busy_vpn), .free_cnt_o(free_cnt)
  );

  tc_issue_pick #(.GROUPS(GROUPS), .LANES(LANES), .DEPTH(OUT_DEPTH),
                  .VPN_W(VPN_W), .WIN_W(WIN_W)) u_pick (
    .grp_vld_i(vld_q), .grp_vpn_i(grp_vpn), .grp_win_i(grp_win),
    .grp_older_i(older_q), .busy_vld_i(busy_vld), .busy_vpn_i(busy_vpn),
    .free_cnt_i(free_cnt), .lane_vld_o(lane_vld), .lane_idx_o(lane_idx)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_vpn[k]        = grp_vpn[lane_idx[k]];
    assign probe_valid_o[k]   = lane_vld[k];
    assign probe_vaddr_o[k]   = grp_q[lane_idx[k]].vaddr;
    assign probe_write_o[k]   = grp_q[lane_idx[k]].mode == MODE_WR;
    assign probe_src_o[k]     = grp_q[lane_idx[k]].src;
    assign probe_cnt_o[k]     = grp_q[lane_idx[k]].cnt;
    assign probe_members_o[k] = grp_q[lane_idx[k]].memb;
  end

  assign req_vpn  = req_vaddr_i[VA_W-1:PAGE_BITS];
  assign req_mode = acc_mode_e'(req_write_i);
  assign add      = req_prefetch_i ? '0 : req_cnt_i;

  always_comb begin
    fire = '0;
    for (int k = 0; k < LANES; k++)
      if (probe_ready_i && lane_vld[k]) fire[lane_idx[k]] = 1'b1;
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = GROUPS - 1; i >= 0; i--) begin
      if (vld_q[i] && !fire[i] && !coalesce_off_i && (grp_q[i].win == cur_win) &&
          (grp_vpn[i] == req_vpn) && (grp_q[i].mode == req_mode) &&
          (grp_q[i].memb < MW'(MAX_MEMB))) begin
        hit     = 1'b1;
        hit_idx = GI_W'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = GI_W'(i);
      end
    end
  end

  assign req_ready_o = free_any;
  assign accept      = req_valid_i && free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      older_q <= '0;
      for (int i = 0; i < GROUPS; i++) grp_q[i] <= '0;
    end else begin
      for (int i = 0; i < GROUPS; i++)
        if (fire[i]) vld_q[i] <= 1'b0;
      if (accept && hit) begin
        grp_q[hit_idx].cnt  <= grp_q[hit_idx].cnt + add;
        grp_q[hit_idx].memb <= grp_q[hit_idx].memb + 1'b1;
      end else if (accept) begin
        vld_q[free_idx]   <= 1'b1;
        grp_q[free_idx]   <= '{vaddr: req_vaddr_i, src: req_src_i, mode: req_mode,
                               win: cur_win, cnt: add, memb: MW'(1)};
        older_q[free_idx] <= vld_q & ~fire;
        for (int i = 0; i < GROUPS; i++) older_q[i][free_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_coalescer_chk.sv
module tc_coalescer_chk #(
  parameter int unsigned LANES     = 2,
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_ready_o,
  input logic [LANES-1:0]           probe_valid_o,
  input logic                       probe_ready_i,
  input logic [LANES-1:0][VA_W-1:0] probe_vaddr_o,
  input logic                       rsp_valid_i
);
  for (genvar k = 1; k < LANES; k++) begin : g_ord
    assert_lane_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      probe_valid_o[k] |-> probe_valid_o[k-1]);
  end

  for (genvar a = 0; a < LANES; a++) begin : g_pa
    for (genvar b = 0; b < LANES; b++) begin : g_pb
      if (a < b) begin : g_u
        assert_page_unique_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (probe_valid_o[a] && probe_valid_o[b]) |->
          (probe_vaddr_o[a][VA_W-1:PAGE_BITS] != probe_vaddr_o[b][VA_W-1:PAGE_BITS]));
      end
      assert_no_reissue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (probe_ready_i && probe_valid_o[a]) |=>
        !(probe_valid_o[b] &&
          (probe_vaddr_o[b][VA_W-1:PAGE_BITS] == $past(probe_vaddr_o[a][VA_W-1:PAGE_BITS]))));
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_o[0] && !probe_ready_i && !rsp_valid_i) |=>
    (probe_valid_o[0] && $stable(probe_vaddr_o[0])));

  assert_full_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !(probe_ready_i && (|probe_valid_o))) |=> !req_ready_o);
endmodule

bind xlat_coalescer tc_coalescer_chk #(.LANES(LANES), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/sim_xlat_coalescer.sv
`timescale 1ns/1ps
module sim_xlat_coalescer;
  localparam int unsigned VA_W = 32, PAGE_BITS = 12, SRC_W = 2, CNT_W = 8;
  localparam int unsigned LANES = 2, WIN_LEN = 4, MW = 4, VPN_W = VA_W - PAGE_BITS;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic coalesce_off_i = 1'b0, req_valid_i = 1'b0, req_ready_o;
  logic [VA_W-1:0] req_vaddr_i = '0;
  logic req_write_i = 1'b0, req_prefetch_i = 1'b0;
  logic [SRC_W-1:0] req_src_i = '0;
  logic [CNT_W-1:0] req_cnt_i = '0;
  logic [LANES-1:0] probe_valid_o;
  logic probe_ready_i = 1'b0;
  logic [LANES-1:0][VA_W-1:0] probe_vaddr_o;
  logic [LANES-1:0] probe_write_o;
  logic [LANES-1:0][SRC_W-1:0] probe_src_o;
  logic [LANES-1:0][CNT_W-1:0] probe_cnt_o;
  logic [LANES-1:0][MW-1:0] probe_members_o;
  logic rsp_valid_i = 1'b0;
  logic [VPN_W-1:0] rsp_vpn_i = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  xlat_coalescer #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SRC_W(SRC_W), .CNT_W(CNT_W),
                   .GROUPS(8), .MAX_MEMB(8), .LANES(LANES), .OUT_DEPTH(4),
                   .WIN_LEN(WIN_LEN), .WIN_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .coalesce_off_i(coalesce_off_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
    .req_write_i(req_write_i), .req_prefetch_i(req_prefetch_i), .req_src_i(req_src_i),
    .req_cnt_i(req_cnt_i), .probe_valid_o(probe_valid_o), .probe_ready_i(probe_ready_i),
    .probe_vaddr_o(probe_vaddr_o), .probe_write_o(probe_write_o), .probe_src_o(probe_src_o),
    .probe_cnt_o(probe_cnt_o), .probe_members_o(probe_members_o),
    .rsp_valid_i(rsp_valid_i), .rsp_vpn_i(rsp_vpn_i)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic align();
    while (cyc % WIN_LEN != 0) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] va, input logic wr, input logic pf,
                      input logic [1:0] src, input logic [7:0] cnt);
    req_vaddr_i = va; req_write_i = wr; req_prefetch_i = pf;
    req_src_i = src; req_cnt_i = cnt; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic pulse();
    probe_ready_i = 1'b1;
    @(negedge clk);
    probe_ready_i = 1'b0;
  endtask

  task automatic respond(input logic [VPN_W-1:0] v);
    rsp_valid_i = 1'b1; rsp_vpn_i = v;
    @(negedge clk);
    rsp_valid_i = 1'b0;
  endtask

  task automatic drain();
    logic [LANES-1:0] m;
    logic [LANES-1:0][VPN_W-1:0] v;
    for (int it = 0; it < 40; it++) begin
      if (!probe_valid_o[0]) break;
      m = probe_valid_o;
      for (int k = 0; k < LANES; k++) v[k] = probe_vaddr_o[k][VA_W-1:PAGE_BITS];
      pulse();
      for (int k = 0; k < LANES; k++) if (m[k]) respond(v[k]);
    end
  endtask

  task automatic t_reset();
    chk("R11 ready in reset", req_ready_o, 1);
    chk("R11 lanes idle in reset", probe_valid_o, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    chk("R11 lanes idle after reset", probe_valid_o, 0);
  endtask

  task automatic t_merge();
    align();
    send(32'h1000_0010, 0, 0, 2'd0, 8'd1);
    send(32'h1000_0ff0, 0, 0, 2'd1, 8'd2);
    send(32'h1000_0020, 0, 1, 2'd2, 8'd5);
    chk("R1 lane0 valid", probe_valid_o[0], 1);
    chk("R1 first member vaddr", probe_vaddr_o[0], 32'h1000_0010);
    chk("R1 first member src", probe_src_o[0], 0);
    chk("R1 member count", probe_members_o[0], 3);
    chk("R5 count skips prefetch", probe_cnt_o[0], 3);
    chk("R6 single group one lane", probe_valid_o[1], 0);
    pulse();
    chk("R6 issued group leaves lanes", probe_valid_o[0], 0);
    respond(20'h10000);
  endtask

  task automatic t_mode();
    align();
    send(32'h2000_0004, 0, 0, 2'd0, 8'd1);
    send(32'h2000_0008, 1, 0, 2'd1, 8'd1);
    chk("R2 read group on lane0", probe_write_o[0], 0);
    chk("R2 read group single member", probe_members_o[0], 1);
    chk("R7 same page not on lane1", probe_valid_o[1], 0);
    pulse();
    chk("R7 page in flight blocks write group", probe_valid_o[0], 0);
    rsp_valid_i = 1'b1; rsp_vpn_i = 20'h20000;
    chk("R10 still blocked during response cycle", probe_valid_o[0], 0);
    @(negedge clk); rsp_valid_i = 1'b0;
    chk("R10 freed next cycle", probe_valid_o[0], 1);
    chk("R2 write group presented", probe_write_o[0], 1);
    pulse();
    respond(20'h20000);
  endtask

  task automatic t_disable();
    coalesce_off_i = 1'b1;
    align();
    send(32'h3000_0000, 0, 0, 2'd0, 8'd1);
    send(32'h3000_0040, 0, 0, 2'd1, 8'd1);
    chk("R4 no merge when off", probe_members_o[0], 1);
    pulse(); respond(20'h30000);
    chk("R4 second group own", probe_vaddr_o[0], 32'h3000_0040);
    chk("R4 second group size", probe_members_o[0], 1);
    pulse(); respond(20'h30000);
    coalesce_off_i = 1'b0;
  endtask

  task automatic t_window();
    align();
    repeat (3) @(negedge clk);
    send(32'h4000_0000, 0, 0, 2'd0, 8'd1);
    send(32'h4000_0010, 0, 0, 2'd1, 8'd1);
    chk("R3 boundary splits group", probe_members_o[0], 1);
    pulse();
    align();
    send(32'h4100_0000, 0, 0, 2'd2, 8'd1);
    chk("R8 later window waits", probe_valid_o[0], 0);
    respond(20'h40000);
    chk("R8 older window first", probe_vaddr_o[0], 32'h4000_0010);
    chk("R8 later window not on lane1", probe_valid_o[1], 0);
    pulse();
    chk("R8 later window after drain", probe_vaddr_o[0], 32'h4100_0000);
    pulse();
    respond(20'h40000); respond(20'h41000);
  endtask

  task automatic t_bypass();
    send(32'h5000_0000, 0, 0, 2'd0, 8'd1);
    pulse();
    align();
    send(32'h5000_0100, 0, 0, 2'd1, 8'd1);
    send(32'h5100_0000, 0, 0, 2'd2, 8'd1);
    chk("R7 younger group bypasses", probe_vaddr_o[0], 32'h5100_0000);
    chk("R7 blocked group not shown", probe_valid_o[1], 0);
    pulse(); respond(20'h51000); respond(20'h50000);
    chk("R7 blocked group after free", probe_vaddr_o[0], 32'h5000_0100);
    pulse(); respond(20'h50000);
  endtask

  task automatic t_lanes();
    align();
    send(32'h6000_0000, 0, 0, 2'd0, 8'd1);
    send(32'h6100_0000, 1, 0, 2'd1, 8'd1);
    send(32'h6200_0000, 0, 0, 2'd2, 8'd1);
    chk("R6 lane0 oldest", probe_vaddr_o[0], 32'h6000_0000);
    chk("R6 lane1 next", probe_vaddr_o[1], 32'h6100_0000);
    repeat (3) @(negedge clk);
    chk("R9 refused probe held", probe_vaddr_o[0], 32'h6000_0000);
    pulse();
    chk("R6 third after cap", probe_vaddr_o[0], 32'h6200_0000);
    pulse();
    respond(20'h60000); respond(20'h61000); respond(20'h62000);
  endtask

  task automatic t_full();
    align();
    for (int i = 0; i < 8; i++) send(32'h7000_0000 + (i << 12), 0, 0, 2'd0, 8'd1);
    chk("R11 ready low when full", req_ready_o, 0);
    req_vaddr_i = 32'h7800_0000; req_valid_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 still full while refused", req_ready_o, 0);
    pulse();
    chk("R11 ready after issue", req_ready_o, 1);
    @(negedge clk); req_valid_i = 1'b0;
    pulse();
    chk("R10 no lane without free entry", probe_valid_o[0], 0);
    for (int i = 0; i < 4; i++) respond(20'h70000 + i);
    drain();
    chk("R11 storage empties", req_ready_o, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_merge();
    t_mode();
    t_disable();
    t_window();
    t_bypass();
    t_lanes();
    t_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule